// File: doc/BRIEF.md
# Answer-to-Reset Header Generator

This block sends a fixed 32-bit answer-to-reset header on a serial data line when a host pulses the reset line of a card-style memory device. The host selects the device by holding the active-low chip select low and pulses the reset input high. Once reset returns low, the block drives the first header bit. It then moves to the next bit on every falling edge of the external serial clock. The header is four bytes, 19h, 55h, AAh and 55h, and each byte goes out least significant bit first.

All external pins are sampled by a fast system clock through two-stage synchronizers. Edges are found by comparing successive synchronized samples, so no logic is clocked by the serial clock itself. A response is refused while the internal non-volatile write flag is set. A response already running is dropped as soon as chip select goes high. After the last bit the block releases the line and waits for a new reset pulse.

Top module: `atr_header_gen`

## Requirements
- R1: After system reset the output enable is low and the block is idle.
- R2: A reset pulse (high, then low) seen while chip select is low and the write flag is clear starts a response, and the output enable goes high after reset falls.
- R3: A reset pulse whose rising edge arrives while the write flag is set starts no response.
- R4: A reset pulse whose rising edge arrives while chip select is high starts no response.
- R5: Before any serial clock falling edge, the data output carries header bit b1, which is bit 0 of byte 19h (value 1).
- R6: Each serial clock falling edge advances one bit. Bit k (k = 0..31) is bit k mod 8 of byte k div 8, and the bytes are 19h, 55h, AAh, 55h in that order.
- R7: The 32nd serial clock falling edge lowers the output enable, and later serial clock pulses do not raise it again.
- R8: Chip select going high during a response ends it. After chip select returns low, serial clock pulses do not restart it without a new reset pulse.
- R9: The output enable is low in every cycle in which chip select is high.
- R10: A serial clock rising edge does not change the data output during a response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| iso_rst | input | 1 | Reset request line from the host, active high |
| cs_n | input | 1 | Chip select, active low |
| ser_clk | input | 1 | Serial clock from the host |
| nv_busy | input | 1 | High while a non-volatile write cycle is running |
| sda_o | output | 1 | Serial data value to drive |
| sda_oe | output | 1 | Drive enable for the serial data pad |

## Verification
Each pin change passes through two synchronizer flops and then through the state register. A change in reset or serial clock therefore shows on the data output or its enable on the third system clock edge after the pin moves. The bench changes pins just after a falling edge of the system clock and samples only after at least four further edges, so every sample lands well after that third edge. The one exception is the enable gating by chip select, which follows the pin in the same cycle. The bench checks it right after raising chip select, before any edge.

// File: rtl/atr_pkg.sv
package atr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_SEND  = 2'd2
    } phase_e;

endpackage

// File: rtl/atr_sync.sv
module atr_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/atr_edge.sv
module atr_edge #(
    parameter int              WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level_i;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign rise_o[i] = level_i[i] & ~prev_q[i];
        assign fall_o[i] = ~level_i[i] & prev_q[i];
    end
endmodule

// File: rtl/atr_hdr_sel.sv
module atr_hdr_sel #(
    parameter int                      HDR_BYTES = 4,
    parameter logic [HDR_BYTES*8-1:0]  HDR_VALUE = 32'h55AA_5519,
    localparam int                     HDR_BITS  = HDR_BYTES * 8,
    localparam int                     IDX_W     = $clog2(HDR_BITS)
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             bit_o
);
    localparam int BYTE_W = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1;

    logic [7:0] byte_tab [HDR_BYTES];

    for (genvar b = 0; b < HDR_BYTES; b++) begin : g_byte
        assign byte_tab[b] = HDR_VALUE[b*8 +: 8];
    end

    logic [BYTE_W-1:0] byte_sel;
    logic [2:0]        bit_sel;

    always_comb begin
        byte_sel = BYTE_W'(idx_i >> 3);
        bit_sel  = idx_i[2:0];
        bit_o    = byte_tab[byte_sel][bit_sel];
    end
endmodule

// File: rtl/atr_header_gen.sv
module atr_header_gen
    import atr_pkg::*;
#(
    parameter int                     SYNC_STAGES = 2,
    parameter int                     HDR_BYTES   = 4,
    parameter logic [HDR_BYTES*8-1:0] HDR_VALUE   = 32'h55AA_5519
) (
    input  logic clk,
    input  logic rst_n,
    input  logic iso_rst,
    input  logic cs_n,
    input  logic ser_clk,
    input  logic nv_busy,
    output logic sda_o,
    output logic sda_oe
);
    localparam int               HDR_BITS = HDR_BYTES * 8;
    localparam int               IDX_W    = $clog2(HDR_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BITS - 1);

    // synchronized pins: [2]=cs_n, [1]=ser_clk, [0]=iso_rst
    logic [2:0] pins_s;
    logic [1:0] edge_rise, edge_fall;

    atr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, ser_clk, iso_rst}),
        .sync_o  (pins_s)
    );

    atr_edge #(.WIDTH(2), .RST_VAL(2'b00)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pins_s[1:0]),
        .rise_o  (edge_rise),
        .fall_o  (edge_fall)
    );

    logic cs_hi, rst_rise, rst_fall, scl_rise, scl_fall;
    assign cs_hi    = pins_s[2];
    assign rst_rise = edge_rise[0];
    assign rst_fall = edge_fall[0];
    assign scl_rise = edge_rise[1];
    assign scl_fall = edge_fall[1];

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (rst_rise && !cs_hi && !nv_busy) seq_d.phase = PH_ARMED;
            end
            PH_ARMED: begin
                if (cs_hi) begin
                    seq_d.phase = PH_IDLE;
                end else if (rst_fall) begin
                    seq_d.phase = PH_SEND;
                    seq_d.idx   = '0;
                end
            end
            PH_SEND: begin
                if (cs_hi) begin
                    seq_d.phase = PH_IDLE;
                    seq_d.idx   = '0;
                end else if (scl_fall) begin
                    if (seq_q.idx == LAST_IDX) begin
                        seq_d.phase = PH_IDLE;
                        seq_d.idx   = '0;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            default: seq_d = '{phase: PH_IDLE, idx: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{phase: PH_IDLE, idx: '0};
        else        seq_q <= seq_d;
    end

    logic hdr_bit;

    atr_hdr_sel #(.HDR_BYTES(HDR_BYTES), .HDR_VALUE(HDR_VALUE)) u_sel (
        .idx_i (seq_q.idx),
        .bit_o (hdr_bit)
    );

    logic sending;
    assign sending = (seq_q.phase == PH_SEND);
    assign sda_o   = sending & hdr_bit;
    assign sda_oe  = sending & ~cs_n;

endmodule

// File: rtl/atr_header_chk.sv
module atr_header_chk
    import atr_pkg::*;
#(
    parameter int IDX_W    = 5,
    parameter int HDR_BITS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             nv_busy,
    input logic             sda_o,
    input logic             sda_oe,
    input phase_e           phase,
    input logic [IDX_W-1:0] idx,
    input logic             cs_hi,
    input logic             rst_rise,
    input logic             scl_rise,
    input logic             scl_fall
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BITS - 1);

    p_cs_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sda_oe);

    p_busy_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && rst_rise && nv_busy) |=> phase == PH_IDLE);

    p_desel_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && rst_rise && cs_hi) |=> phase == PH_IDLE);

    p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SEND && !cs_hi && scl_fall && idx != LAST_IDX)
            |=> (phase == PH_SEND && idx == $past(idx) + 1'b1));

    p_last_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SEND && scl_fall && idx == LAST_IDX) |=> !sda_oe);

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && cs_hi) |=> phase == PH_IDLE);

    p_rise_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SEND && !cs_hi && scl_rise && !scl_fall) |=> $stable(sda_o));

endmodule

bind atr_header_gen atr_header_chk #(.IDX_W(IDX_W), .HDR_BITS(HDR_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .nv_busy  (nv_busy),
    .sda_o    (sda_o),
    .sda_oe   (sda_oe),
    .phase    (seq_q.phase),
    .idx      (seq_q.idx),
    .cs_hi    (cs_hi),
    .rst_rise (rst_rise),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
);

// File: tb/tb_atr_header_gen.sv
module tb_atr_header_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iso_rst = 1'b0;
    logic cs_n = 1'b1;
    logic ser_clk = 1'b0;
    logic nv_busy = 1'b0;
    logic sda_o, sda_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    atr_header_gen dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .iso_rst (iso_rst),
        .cs_n    (cs_n),
        .ser_clk (ser_clk),
        .nv_busy (nv_busy),
        .sda_o   (sda_o),
        .sda_oe  (sda_oe)
    );

    localparam logic [7:0] HB [4] = '{8'h19, 8'h55, 8'hAA, 8'h55};

    function automatic logic exp_bit(int k);
        return HB[k / 8][k % 8];
    endfunction

    // trigger table: {cs_n at reset pulse, nv_busy at reset pulse, expected sda_oe}
    localparam int NVEC = 6;
    localparam logic [2:0] TRIG_VEC [NVEC] = '{
        3'b001, 3'b100, 3'b010, 3'b110, 3'b001, 3'b010
    };

    task automatic check(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_rst();
        iso_rst = 1'b1;
        settle();
        iso_rst = 1'b0;
        settle();
    endtask

    task automatic scl_up();
        ser_clk = 1'b1;
        settle();
    endtask

    task automatic scl_down();
        ser_clk = 1'b0;
        settle();
    endtask

    task automatic deselect_cycle();
        cs_n = 1'b1;
        settle();
        cs_n = 1'b0;
        settle();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", sda_oe, 1'b0);
        rst_n = 1'b1;
        settle();
        cs_n = 1'b0;
        settle();
        check("R1", sda_oe, 1'b0);

        // R2, R3, R4: trigger qualification table
        for (int v = 0; v < NVEC; v++) begin
            cs_n    = TRIG_VEC[v][2];
            nv_busy = TRIG_VEC[v][1];
            settle();
            pulse_rst();
            nv_busy = 1'b0;
            cs_n    = 1'b0;
            settle();
            if (TRIG_VEC[v][2])      check("R4", sda_oe, TRIG_VEC[v][0]);
            else if (TRIG_VEC[v][1]) check("R3", sda_oe, TRIG_VEC[v][0]);
            else                     check("R2", sda_oe, TRIG_VEC[v][0]);
            deselect_cycle();
        end

        // R5, R6, R10: full header
        pulse_rst();
        check("R2", sda_oe, 1'b1);
        check("R5", sda_o, exp_bit(0));
        for (int k = 1; k < 32; k++) begin
            scl_up();
            check("R10", sda_o, exp_bit(k - 1));
            scl_down();
            check("R6", sda_o, exp_bit(k));
            check("R6", sda_oe, 1'b1);
        end

        // R7: release after bit 32 and stay released
        scl_up();
        scl_down();
        check("R7", sda_oe, 1'b0);
        for (int p = 0; p < 3; p++) begin
            scl_up();
            scl_down();
            check("R7", sda_oe, 1'b0);
        end

        // R8, R9: abort mid-stream
        pulse_rst();
        for (int k = 0; k < 10; k++) begin
            scl_up();
            scl_down();
        end
        check("R6", sda_o, exp_bit(10));
        @(negedge clk);
        cs_n = 1'b1;
        #1;
        check("R9", sda_oe, 1'b0);
        settle();
        check("R9", sda_oe, 1'b0);
        cs_n = 1'b0;
        settle();
        check("R8", sda_oe, 1'b0);
        for (int p = 0; p < 2; p++) begin
            scl_up();
            scl_down();
            check("R8", sda_oe, 1'b0);
        end

        // R8: a fresh reset pulse restarts from b1
        pulse_rst();
        check("R8", sda_oe, 1'b1);
        check("R5", sda_o, exp_bit(0));
        scl_up();
        scl_down();
        check("R6", sda_o, exp_bit(1));

        // R4: chip select high while armed cancels
        deselect_cycle();
        iso_rst = 1'b1;
        settle();
        cs_n = 1'b1;
        settle();
        iso_rst = 1'b0;
        settle();
        cs_n = 1'b0;
        settle();
        check("R4", sda_oe, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule